// File: doc/BRIEF.md
# Receive Character Output Formatter

This block takes one receive channel's character and registers it onto three outputs: an 8-bit data bus, a 3-bit status bus and an odd-parity bit with its own output-enable. A 2-bit decoder-mode select chooses between two ways of presenting the character.

In decoded mode the data bus carries the decoded byte and the status bus carries the decoder's status code. In bypass mode the raw 10-bit character is split across the two buses. Its upper eight bits go onto the data bus and its two low bits go onto status[1:0]. Status[2] then shows whether that character is a comma.

A second 2-bit select controls the parity output-enable. A pad driver downstream uses that enable to put the parity pin in high-Z. All outputs are registered on the rising edge of the receive interface clock.

Top module: `rx_char_formatter`

## Requirements
- R1: While rst_n is low at a rising clock edge, the next outputs are rx_data=0, rx_status=0, rx_parity=1 and rx_parity_oe=0.
- R2: Outputs change only at a rising clock edge. An input change between edges does not show on any output until the next edge.
- R3: When dec_mode is 01 or 10 (decoder enabled; 11 is treated the same way), the next edge loads rx_data=dec_byte and rx_status=dec_status.
- R4: When dec_mode is 00 (bypass), the next edge loads rx_data=raw_char[9:2] and rx_status[1:0]=raw_char[1:0]. Raw bit 9 lands on rx_data[7] and raw bit 0 lands on rx_status[0].
- R5: In bypass, rx_status[2] equals the comma_det value that was sampled with the same character.
- R6: In decoded mode, comma_det and raw_char have no effect on rx_data or rx_status.
- R7: rx_parity is odd parity of the registered rx_data: the XOR of rx_data and rx_parity is 1.
- R8: rx_parity_oe is high after an edge at which par_mode was nonzero (01, 10 or 11), and low after an edge at which par_mode was 00.
- R9: A dec_mode change takes effect on the very next edge. rx_parity at that edge matches the data selected under the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raw_char | input | 10 | Raw received 10-bit character |
| dec_byte | input | 8 | Decoded data or special character |
| dec_status | input | 3 | Decoder status code |
| comma_det | input | 1 | High when raw_char is a comma character |
| dec_mode | input | 2 | Decoder select: 00 bypass, 01/10 decoded |
| par_mode | input | 2 | Parity select: 00 disabled, else enabled |
| rx_data | output | 8 | Registered data bus |
| rx_status | output | 3 | Registered status bus |
| rx_parity | output | 1 | Odd parity over rx_data |
| rx_parity_oe | output | 1 | Parity driver enable |

## Verification
A mode switch and the parity computation can land on the same edge, because parity is taken over whichever data the new mode selects. The bench alternates dec_mode between bypass and decoded on back-to-back cycles, with raw and decoded inputs whose parities differ. At each edge it checks rx_data against the mode just applied and checks rx_parity as odd parity of that data. It also switches par_mode in the same cycles and checks that the enable follows at the same edge.

// File: rtl/rxf_pkg.sv
// Package: shared encodings for the receive character output formatter.
// Assumes the three-level selects arrive already encoded as 2-bit codes.
package rxf_pkg;
    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_MID  = 2'b01,
        LVL_HIGH = 2'b10,
        LVL_RSVD = 2'b11
    } lvl3_t;

    // A select counts as active at any level above LOW.
    function automatic logic lvl_active(input logic [1:0] code);
        return (lvl3_t'(code) != LVL_LOW);
    endfunction
endpackage

// File: rtl/rxf_sel_decode.sv
// Module: reduces one encoded three-level select to an "active" flag.
// Assumes 00 = LOW (inactive); MID, HIGH and the spare code are all active.
module rxf_sel_decode (
    input  logic [1:0] sel_code,
    output logic       sel_active
);
    import rxf_pkg::*;

    // Map the level code to a single enable.
    always_comb begin
        sel_active = lvl_active(sel_code);
    end
endmodule

// File: rtl/rxf_path_mux.sv
// Module: chooses the next data and status values for the output register.
// Assumes STAT_W == RAW_W - DATA_W + 1, so the raw low bits plus the comma
// flag fill the status bus exactly in bypass mode.
module rxf_path_mux #(
    parameter int RAW_W  = 10,
    parameter int DATA_W = 8,
    parameter int STAT_W = 3
) (
    input  logic              use_decoder,
    input  logic [RAW_W-1:0]  raw_char,
    input  logic [DATA_W-1:0] dec_byte,
    input  logic [STAT_W-1:0] dec_status,
    input  logic              comma_det,
    output logic [DATA_W-1:0] nxt_data,
    output logic [STAT_W-1:0] nxt_status
);
    localparam int LOW_W = RAW_W - DATA_W;

    // Split the raw character across the buses or pass the decoder result.
    always_comb begin
        if (use_decoder) begin
            nxt_data   = dec_byte;
            nxt_status = dec_status;
        end else begin
            nxt_data   = raw_char[RAW_W-1 -: DATA_W];
            nxt_status = {comma_det, raw_char[LOW_W-1:0]};
        end
    end
endmodule

// File: rtl/rxf_odd_parity.sv
// Module: odd parity generator built as an XOR chain over the byte.
// Assumes the result is registered by the caller.
module rxf_odd_parity #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] din,
    output logic              odd_bit
);
    logic [DATA_W:0] chain;

    assign chain[0] = 1'b1;
    genvar gi;
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_xor
            assign chain[gi+1] = chain[gi] ^ din[gi];
        end
    endgenerate
    assign odd_bit = chain[DATA_W];
endmodule

// File: rtl/rx_char_formatter.sv
// Module: top of the receive character output formatter. It registers the
// selected data/status, odd parity and the parity driver enable.
// Assumes a synchronous active-low reset and that the selects are 2-bit codes.
module rx_char_formatter #(
    parameter int RAW_W  = 10,
    parameter int DATA_W = 8,
    parameter int STAT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RAW_W-1:0]  raw_char,
    input  logic [DATA_W-1:0] dec_byte,
    input  logic [STAT_W-1:0] dec_status,
    input  logic              comma_det,
    input  logic [1:0]        dec_mode,
    input  logic [1:0]        par_mode,
    output logic [DATA_W-1:0] rx_data,
    output logic [STAT_W-1:0] rx_status,
    output logic              rx_parity,
    output logic              rx_parity_oe
);
    localparam int LOW_W = RAW_W - DATA_W;

    logic              use_decoder;
    logic              par_enable;
    logic [DATA_W-1:0] nxt_data;
    logic [STAT_W-1:0] nxt_status;
    logic              nxt_parity;

    rxf_sel_decode u_dec_sel (.sel_code(dec_mode), .sel_active(use_decoder));
    rxf_sel_decode u_par_sel (.sel_code(par_mode), .sel_active(par_enable));

    rxf_path_mux #(.RAW_W(RAW_W), .DATA_W(DATA_W), .STAT_W(STAT_W)) u_mux (
        .use_decoder(use_decoder),
        .raw_char   (raw_char),
        .dec_byte   (dec_byte),
        .dec_status (dec_status),
        .comma_det  (comma_det),
        .nxt_data   (nxt_data),
        .nxt_status (nxt_status)
    );

    rxf_odd_parity #(.DATA_W(DATA_W)) u_par (
        .din    (nxt_data),
        .odd_bit(nxt_parity)
    );

    // Output register: loads the selected character, its parity and the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data      <= '0;
            rx_status    <= '0;
            rx_parity    <= 1'b1;
            rx_parity_oe <= 1'b0;
        end else begin
            rx_data      <= nxt_data;
            rx_status    <= nxt_status;
            rx_parity    <= nxt_parity;
            rx_parity_oe <= par_enable;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (rx_data == '0 && rx_status == '0 && rx_parity && !rx_parity_oe));

    // R3
    decoded_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_mode != 2'b00) |=> (rx_data == $past(dec_byte) && rx_status == $past(dec_status)));

    // R4
    bypass_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_mode == 2'b00) |=> (rx_data == $past(raw_char[RAW_W-1 -: DATA_W])
                                 && rx_status[LOW_W-1:0] == $past(raw_char[LOW_W-1:0])));

    // R5
    bypass_comma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_mode == 2'b00) |=> (rx_status[STAT_W-1] == $past(comma_det)));

    // R7
    odd_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (^{rx_data, rx_parity}) == 1'b1);

    // R8
    parity_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rx_parity_oe == ($past(par_mode) != 2'b00)));
endmodule

// File: tb/rx_char_formatter_bench.sv
module rx_char_formatter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] raw_char = '0;
    logic [7:0] dec_byte = '0;
    logic [2:0] dec_status = '0;
    logic       comma_det = 1'b0;
    logic [1:0] dec_mode = 2'b00;
    logic [1:0] par_mode = 2'b00;
    logic [7:0] rx_data;
    logic [2:0] rx_status;
    logic       rx_parity;
    logic       rx_parity_oe;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rx_char_formatter u_rx_char_formatter (
        .clk(clk), .rst_n(rst_n), .raw_char(raw_char), .dec_byte(dec_byte),
        .dec_status(dec_status), .comma_det(comma_det), .dec_mode(dec_mode),
        .par_mode(par_mode), .rx_data(rx_data), .rx_status(rx_status),
        .rx_parity(rx_parity), .rx_parity_oe(rx_parity_oe)
    );

    task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic odd_of(input logic [7:0] d);
        return ~(^d);
    endfunction

    // Drive one set of inputs at the falling edge, then sample just after the rising edge.
    task automatic apply(input logic [9:0] r, input logic [7:0] b, input logic [2:0] s,
                         input logic c, input logic [1:0] dm, input logic [1:0] pm);
        @(negedge clk);
        raw_char = r; dec_byte = b; dec_status = s; comma_det = c;
        dec_mode = dm; par_mode = pm;
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        apply(10'h3FF, 8'hFF, 3'h7, 1'b1, 2'b10, 2'b10);
        chk("R1 data", {2'b0, rx_data}, 10'h0);
        chk("R1 status", {7'b0, rx_status}, 10'h0);
        chk("R1 parity", {9'b0, rx_parity}, 10'h1);
        chk("R1 oe", {9'b0, rx_parity_oe}, 10'h0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_decoded();
        apply(10'h155, 8'hA7, 3'h5, 1'b0, 2'b01, 2'b01);
        chk("R3 data mid", {2'b0, rx_data}, 10'h0A7);
        chk("R3 status mid", {7'b0, rx_status}, 10'h5);
        chk("R7 parity", {9'b0, rx_parity}, {9'b0, odd_of(8'hA7)});
        apply(10'h2AA, 8'h3C, 3'h2, 1'b0, 2'b10, 2'b01);
        chk("R3 data high", {2'b0, rx_data}, 10'h03C);
        chk("R3 status high", {7'b0, rx_status}, 10'h2);
        apply(10'h000, 8'h81, 3'h6, 1'b0, 2'b11, 2'b01);
        chk("R3 data spare code", {2'b0, rx_data}, 10'h081);
    endtask

    task automatic t_comma_ignored();
        apply(10'h3FF, 8'h12, 3'h1, 1'b1, 2'b01, 2'b10);
        chk("R6 data", {2'b0, rx_data}, 10'h012);
        chk("R6 status", {7'b0, rx_status}, 10'h1);
    endtask

    task automatic t_bypass();
        // 10'b10_1100_1101: upper 8 = 8'hB3, low 2 = 2'b01
        apply(10'h2CD, 8'hFF, 3'h7, 1'b0, 2'b00, 2'b10);
        chk("R4 data", {2'b0, rx_data}, 10'h0B3);
        chk("R4 low bits", {8'b0, rx_status[1:0]}, 10'h1);
        chk("R5 no comma", {9'b0, rx_status[2]}, 10'h0);
        chk("R7 parity bypass", {9'b0, rx_parity}, {9'b0, odd_of(8'hB3)});
        apply(10'h17C, 8'h00, 3'h0, 1'b1, 2'b00, 2'b10);
        chk("R4 data 2", {2'b0, rx_data}, 10'h05F);
        chk("R5 comma", {7'b0, rx_status}, 10'h4);
        apply(10'h201, 8'h00, 3'h0, 1'b0, 2'b00, 2'b10);
        chk("R4 bit9 to data7", {2'b0, rx_data}, 10'h080);
        chk("R4 bit0 to status0", {7'b0, rx_status}, 10'h1);
    endtask

    task automatic t_parity_off();
        apply(10'h000, 8'h01, 3'h0, 1'b0, 2'b01, 2'b00);
        chk("R8 oe off", {9'b0, rx_parity_oe}, 10'h0);
        chk("R7 value when off", {9'b0, rx_parity}, 10'h0);
        apply(10'h000, 8'h01, 3'h0, 1'b0, 2'b01, 2'b11);
        chk("R8 oe spare code", {9'b0, rx_parity_oe}, 10'h1);
    endtask

    task automatic t_registered();
        apply(10'h000, 8'h55, 3'h3, 1'b0, 2'b01, 2'b01);
        // change inputs between edges; outputs must hold
        raw_char = 10'h3FF; dec_byte = 8'hAA; dec_status = 3'h4;
        dec_mode = 2'b00; par_mode = 2'b00; comma_det = 1'b1;
        #1;
        chk("R2 data held", {2'b0, rx_data}, 10'h055);
        chk("R2 status held", {7'b0, rx_status}, 10'h3);
        chk("R2 oe held", {9'b0, rx_parity_oe}, 10'h1);
        @(posedge clk); #1;
        chk("R2 data after edge", {2'b0, rx_data}, 10'h0FF);
        chk("R2 status after edge", {7'b0, rx_status}, 10'h7);
    endtask

    task automatic t_mode_switch();
        // raw upper byte 8'h03 (even), decoded byte 8'h07 (odd)
        for (int i = 0; i < 6; i++) begin
            logic [1:0] m;
            logic [7:0] ed;
            m  = (i % 2 == 0) ? 2'b00 : 2'b10;
            ed = (m == 2'b00) ? 8'h03 : 8'h07;
            apply(10'h00E, 8'h07, 3'h1, 1'b1, m, (i % 3 == 0) ? 2'b00 : 2'b01);
            chk("R9 data", {2'b0, rx_data}, {2'b0, ed});
            chk("R9 parity", {9'b0, rx_parity}, {9'b0, odd_of(ed)});
            chk("R8 oe switch", {9'b0, rx_parity_oe}, (i % 3 == 0) ? 10'h0 : 10'h1);
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        t_decoded();
        t_comma_ignored();
        t_bypass();
        t_parity_off();
        t_registered();
        t_mode_switch();
        t_reset();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule